// File: doc/BRIEF.md
# Serial Clock-Calendar Slave with Parameter Memory

This block sits behind a three-wire bit-banged port: an active-low select, a serial clock and one data line whose direction the host chooses. The host shifts bytes in most significant bit first on the rising edge of the serial clock. When the host reads, the block shifts a loaded byte out, most significant bit first, on the falling edge. The port inputs pass through a configurable synchronizer, so the host may be asynchronous to `clk`.

The first byte of each transaction is a compact command. It can address four bytes of a 32-bit seconds counter, a write-only test register, a write-only protect register, twenty directly addressed parameter bytes, or a 256-byte parameter memory that is reached by sector and offset. A small sequencer steps through the command byte, the parameter byte and the extra data byte. The protect flag blocks every write command except a write to the protect register itself.

The seconds counter counts from 1 January 1904. A 1 Hz tick advances it. It can be preset from a 1970-based value, and the block adds the fixed epoch difference.

Top module: `srtc_pram_top`

## Requirements
- R1: While `ser_en_n` is high, serial clock edges are ignored. A partly received byte keeps its bit count, and a partly sent byte keeps its remaining bits.
- R2: With `host_drv` high, one bit of `ser_din` is captured on each rising edge of `ser_clk`, MSB first. Every eighth bit completes a byte, and the block then acts on it.
- R3: With `host_drv` low, each falling edge of `ser_clk` presents the next bit of the loaded byte on `ser_dout`, MSB first. Once all eight bits have been sent, `ser_dout` holds the last bit. `ser_doe` is high exactly when `ser_en_n` and `host_drv` are both low.
- R4: Command bit 7 = 1 means read and 0 means write. If bits 6:3 are not 0111, bits 1:0 must be 01. Bits 6:2 = 000ss select seconds byte ss, where ss=0 is the least significant byte. A read of a seconds byte (0x81, 0x85, 0x89, 0x8D) loads that byte for output.
- R5: Bits 6:2 = 1aaaa address parameter byte aaaa, and 010aa address byte 0x10+aa. These twenty bytes are the same storage as sector 0 of the extended memory.
- R6: A command with bits 6:3 = 0111 takes its sector from bits 2:0. The next byte gives the offset in bits 6:2; its bits 7 and 1:0 are ignored. The memory index is sector*32+offset. A read loads that byte for output. A write takes a third byte as the data.
- R7: Every other command byte is discarded, including the read forms of the test (0xB1) and protect (0xB5) codes. The next byte is then decoded as a new command.
- R8: The protect flag is loaded from bit 7 of the byte written with command 0x35. While the flag is set, every other write command is ignored, so its following bytes are decoded as commands. Reset clears the flag.
- R9: A write to a seconds byte or to the test register (0x31) consumes one data byte and has no effect.
- R10: Each `tick_1hz` cycle adds one to the seconds counter. `time_load` sets the counter to `time_unix`+2082844800, and it takes priority over a tick in the same cycle.
- R11: After reset, the sequencer waits for a command, `ser_dout` is 0 and the seconds counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en_n | input | 1 | Active-low transaction select |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_din | input | 1 | Data line value while the host drives it |
| host_drv | input | 1 | High while the host drives the data line |
| ser_dout | output | 1 | Data bit presented to the host |
| ser_doe | output | 1 | Data line drive enable toward the host |
| tick_1hz | input | 1 | One-cycle pulse each second |
| time_load | input | 1 | Preset strobe for the seconds counter |
| time_unix | input | 32 | Preset value, seconds since 1970 |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, the 1904 epoch difference and the 256-byte memory fixed by the command format. With these values every memory byte can be reached through an extended write and then read back. Every direct code of both forms, every seconds byte and every tick/load ordering can also be tried within the cycle limit. The sweep compares against an arithmetic pattern held in the bench, and it interleaves disabled clocking, rejected codes and protected writes. A miscount at any byte boundary would therefore shift every later result.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    localparam int BYTE_W    = 8;
    localparam int SECT_W    = 3;
    localparam int OFS_W     = 5;
    localparam int RAM_AW    = SECT_W + OFS_W;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int SEC_W     = 32;

    typedef enum logic [2:0] {
        K_NONE, K_SEC, K_TEST, K_PROT, K_RAM, K_EXT
    } kind_e;

    typedef struct packed {
        logic              rd;
        kind_e             kind;
        logic [RAM_AW-1:0] idx;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_CMD, ST_PARAM, ST_DATA
    } phase_e;

    // Compact command decoder: idx carries the seconds byte, the memory
    // index or the sector, depending on kind.
    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t       c;
        logic [4:0] f;
        c.rd   = b[7];
        c.kind = K_NONE;
        c.idx  = '0;
        f      = b[6:2];
        if (b[6:3] == 4'b0111) begin
            c.kind = K_EXT;
            c.idx  = {{(RAM_AW-SECT_W){1'b0}}, b[2:0]};
        end else if (b[1:0] == 2'b01) begin
            if (f[4:2] == 3'b000) begin
                c.kind = K_SEC;
                c.idx  = {{(RAM_AW-2){1'b0}}, f[1:0]};
            end else if (f == 5'b01100 && !c.rd) begin
                c.kind = K_TEST;
            end else if (f == 5'b01101 && !c.rd) begin
                c.kind = K_PROT;
            end else if (f[4:2] == 3'b010) begin
                c.kind = K_RAM;
                c.idx  = {4'h1, 2'b00, f[1:0]};
            end else if (f[4]) begin
                c.kind = K_RAM;
                c.idx  = {4'h0, f[3:0]};
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/srtc_shift.sv
module srtc_shift
    import srtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BITS        = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_n,
    input  logic            sclk,
    input  logic            din,
    input  logic            drv,
    input  logic            load,
    input  logic [BITS-1:0] load_byte,
    output logic            byte_vld,
    output logic [BITS-1:0] byte_data,
    output logic            dout
);
    localparam int ICNT_W = $clog2(BITS);
    localparam int OCNT_W = $clog2(BITS + 1);
    localparam logic [3:0] SYNC_RST = 4'b1001; // {en_n, sclk, din, drv}

    logic en_s, clk_s, din_s, drv_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign {en_s, clk_s, din_s, drv_s} = {en_n, sclk, din, drv};
        end else begin : g_sync
            logic [3:0] stg [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= SYNC_RST;
                end else begin
                    stg[0] <= {en_n, sclk, din, drv};
                    for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign {en_s, clk_s, din_s, drv_s} = stg[SYNC_STAGES-1];
        end
    endgenerate

    logic              clk_q;
    logic              rise, fall, active;
    logic [BITS-2:0]   in_sh;
    logic [ICNT_W-1:0] in_cnt;
    logic [BITS-1:0]   out_sh;
    logic [OCNT_W-1:0] out_cnt;

    assign rise   = clk_s & ~clk_q;
    assign fall   = ~clk_s & clk_q;
    assign active = ~en_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q     <= 1'b0;
            in_sh     <= '0;
            in_cnt    <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            clk_q    <= clk_s;
            byte_vld <= 1'b0;
            if (active && drv_s && rise) begin
                if (in_cnt == ICNT_W'(BITS - 1)) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {in_sh, din_s};
                    in_cnt    <= '0;
                end else begin
                    in_sh  <= {in_sh[BITS-3:0], din_s};
                    in_cnt <= in_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sh  <= '0;
            out_cnt <= '0;
            dout    <= 1'b0;
        end else if (load) begin
            out_sh  <= load_byte;
            out_cnt <= OCNT_W'(BITS);
        end else if (active && !drv_s && fall && out_cnt != '0) begin
            dout    <= out_sh[BITS-1];
            out_sh  <= {out_sh[BITS-2:0], 1'b0};
            out_cnt <= out_cnt - 1'b1;
        end
    end

    AST_DISABLED_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        en_s |=> $stable(in_cnt)); // R1
    AST_DISABLED_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en_s && !load) |=> ($stable(out_cnt) && $stable(dout))); // R1
    AST_NO_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !drv_s |=> !byte_vld); // R2
    AST_DOUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!fall || drv_s) |=> $stable(dout)); // R3

endmodule

// File: rtl/srtc_seconds.sv
module srtc_seconds
    import srtc_pkg::*;
#(
    parameter logic [SEC_W-1:0] EPOCH_OFS = 32'd2082844800
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_unix,
    output logic [SEC_W-1:0] secs
);
    always_ff @(posedge clk) begin
        if (rst)       secs <= '0;
        else if (load) secs <= load_unix + EPOCH_OFS;
        else if (tick) secs <= secs + 1'b1;
    end

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> secs == $past(secs) + SEC_W'(1)); // R10
    AST_LOAD_EPOCH: assert property (@(posedge clk) disable iff (rst)
        load |=> secs == $past(load_unix) + EPOCH_OFS); // R10

endmodule

// File: rtl/srtc_pram.sv
module srtc_pram
    import srtc_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int AW    = RAM_AW,
    parameter int DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/srtc_ctrl.sv
module srtc_ctrl
    import srtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [SEC_W-1:0]  secs,
    output logic              load,
    output logic [BYTE_W-1:0] load_byte
);
    phase_e            phase;
    cmd_t              cur;
    cmd_t              dec;
    logic [OFS_W-1:0]  alt;
    logic              wp;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_wa, ram_ra;
    logic [BYTE_W-1:0] ram_rd;
    logic [BYTE_W-1:0] sec_byte;

    assign dec      = decode_cmd(byte_data);
    assign sec_byte = secs[{dec.idx[1:0], 3'b000} +: BYTE_W];
    assign ram_ra   = (phase == ST_PARAM) ? {cur.idx[SECT_W-1:0], byte_data[6:2]}
                                          : dec.idx;

    always_comb begin
        ram_we = 1'b0;
        ram_wa = cur.idx;
        if (byte_vld) begin
            if (phase == ST_PARAM && cur.kind == K_RAM && !cur.rd) begin
                ram_we = 1'b1;
            end else if (phase == ST_DATA) begin
                ram_we = 1'b1;
                ram_wa = {cur.idx[SECT_W-1:0], alt};
            end
        end
    end

    srtc_pram u_pram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_wa),
        .wdata (byte_data),
        .raddr (ram_ra),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_CMD;
            cur       <= '0;
            alt       <= '0;
            wp        <= 1'b0;
            load      <= 1'b0;
            load_byte <= '0;
        end else begin
            load <= 1'b0;
            if (byte_vld) begin
                unique case (phase)
                    ST_CMD: begin
                        if (dec.kind != K_NONE) begin
                            if (dec.rd) begin
                                case (dec.kind)
                                    K_SEC: begin load <= 1'b1; load_byte <= sec_byte; end
                                    K_RAM: begin load <= 1'b1; load_byte <= ram_rd;   end
                                    K_EXT: begin cur <= dec; phase <= ST_PARAM;       end
                                    default: ;
                                endcase
                            end else if (dec.kind == K_PROT || !wp) begin
                                cur   <= dec;
                                phase <= ST_PARAM;
                            end
                        end
                    end
                    ST_PARAM: begin
                        phase <= ST_CMD;
                        if (cur.kind == K_PROT) begin
                            wp <= byte_data[7];
                        end else if (cur.kind == K_EXT) begin
                            if (cur.rd) begin
                                load      <= 1'b1;
                                load_byte <= ram_rd;
                            end else begin
                                alt   <= byte_data[6:2];
                                phase <= ST_DATA;
                            end
                        end
                    end
                    default: phase <= ST_CMD;
                endcase
            end
        end
    end

    AST_LOAD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        load |-> $past(byte_vld)); // R4
    AST_DATA_PHASE_EXT: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_DATA) |-> (cur.kind == K_EXT && !cur.rd)); // R6
    AST_INVALID_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && phase == ST_CMD && dec.kind == K_NONE)
            |=> (phase == ST_CMD && !load)); // R7
    AST_PROTECT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && phase == ST_CMD && wp && !byte_data[7] && dec.kind != K_PROT)
            |=> phase == ST_CMD); // R8

endmodule

// File: rtl/srtc_pram_top.sv
module srtc_pram_top
    import srtc_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [SEC_W-1:0]  EPOCH_OFS   = 32'd2082844800
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_en_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             host_drv,
    output logic             ser_dout,
    output logic             ser_doe,
    input  logic             tick_1hz,
    input  logic             time_load,
    input  logic [SEC_W-1:0] time_unix
);
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              out_load;
    logic [BYTE_W-1:0] out_byte;
    logic [SEC_W-1:0]  secs;

    assign ser_doe = ~ser_en_n & ~host_drv;

    srtc_shift #(.SYNC_STAGES(SYNC_STAGES), .BITS(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .en_n      (ser_en_n),
        .sclk      (ser_clk),
        .din       (ser_din),
        .drv       (host_drv),
        .load      (out_load),
        .load_byte (out_byte),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .dout      (ser_dout)
    );

    srtc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .secs      (secs),
        .load      (out_load),
        .load_byte (out_byte)
    );

    srtc_seconds #(.EPOCH_OFS(EPOCH_OFS)) u_secs (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1hz),
        .load      (time_load),
        .load_unix (time_unix),
        .secs      (secs)
    );

endmodule

// File: tb/srtc_pram_top_tb.sv
`timescale 1ns/1ps
module srtc_pram_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_en_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, host_drv = 1'b1;
    logic        tick_1hz = 1'b0, time_load = 1'b0;
    logic [31:0] time_unix = '0;
    logic        ser_dout, ser_doe;

    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [7:0]  model [256];
    logic [31:0] exp_sec;
    logic [7:0]  r;

    always #2 clk = ~clk;

    srtc_pram_top u_dut (
        .clk(clk), .rst(rst), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .host_drv(host_drv), .ser_dout(ser_dout),
        .ser_doe(ser_doe), .tick_1hz(tick_1hz), .time_load(time_load),
        .time_unix(time_unix)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        host_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            ser_din = b[i];
            waitc(4);
            ser_clk = 1'b1;
            waitc(4);
            ser_clk = 1'b0;
        end
        waitc(6);
    endtask

    task automatic recv_bits(input int n, inout logic [7:0] v);
        host_drv = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b1;
            waitc(4);
            ser_clk = 1'b0;
            waitc(4);
            v = {v[6:0], ser_dout};
        end
    endtask

    task automatic recv(output logic [7:0] v);
        logic [7:0] t = '0;
        recv_bits(8, t);
        v = t;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 73 + 29) & 255);
    endfunction

    task automatic sec_check(input string tag);
        for (int k = 0; k < 4; k++) begin
            send(8'h81 | 8'(k << 2));
            recv(r);
            chk(tag, r, exp_sec[8*k +: 8]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(2);
        // R11: reset state
        chk("R11 dout", ser_dout, 0);
        chk("R3 doe disabled", ser_doe, 0);
        ser_en_n = 1'b0;
        waitc(4);
        exp_sec = 0;
        sec_check("R11 seconds zero");

        // R6: extended write over all 256 bytes
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 32; a++) begin
                send(8'h38 | 8'(s));
                send({1'b0, 5'(a), 2'b00});
                send(pat(s * 32 + a));
                model[s * 32 + a] = pat(s * 32 + a);
            end
        // R6: extended read back, don't-care bits set in the offset byte
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 32; a++) begin
                send(8'hB8 | 8'(s));
                send({1'b1, 5'(a), 2'b10});
                recv(r);
                chk("R6 ext read", r, model[s * 32 + a]);
            end

        // R5: direct reads alias sector 0
        for (int a = 0; a < 16; a++) begin
            send(8'hC1 | 8'(a << 2));
            recv(r);
            chk("R5 direct low", r, model[a]);
        end
        for (int a = 0; a < 4; a++) begin
            send(8'hA1 | 8'(a << 2));
            recv(r);
            chk("R5 direct high", r, model[16 + a]);
        end
        send(8'h41 | 8'(9 << 2)); send(8'h3C); model[9] = 8'h3C;
        send(8'h21 | 8'(2 << 2)); send(8'hC3); model[18] = 8'hC3;
        send(8'hB8); send(8'(9 << 2)); recv(r);
        chk("R5 direct write low", r, 8'h3C);
        send(8'hB8); send(8'(18 << 2)); recv(r);
        chk("R5 direct write high", r, 8'hC3);

        // R3: output enable and hold after the last bit
        host_drv = 1'b0; waitc(1);
        chk("R3 doe on", ser_doe, 1);
        host_drv = 1'b1; waitc(1);
        chk("R3 doe off", ser_doe, 0);
        send(8'hC1 | 8'(4 << 2)); recv(r);
        chk("R3 byte", r, model[4]);
        recv_bits(1, r);
        chk("R3 hold last", ser_dout, model[4][0]);

        // R1: disabled edges ignored, both directions
        ser_en_n = 1'b1; waitc(4);
        send(8'hFF);
        ser_en_n = 1'b0; waitc(4);
        send(8'hC1 | 8'(3 << 2));
        r = '0;
        recv_bits(4, r);
        ser_en_n = 1'b1; waitc(4);
        recv_bits(4, r);
        waitc(4);
        ser_en_n = 1'b0; waitc(4);
        r = {4'h0, r[7:4]};
        recv_bits(4, r);
        chk("R1 disabled ignored", r, model[3]);

        // R7: rejected codes followed by a good read
        send(8'hB1); send(8'hB5); send(8'h03); send(8'h12); send(8'h00);
        send(8'hC1 | 8'(2 << 2)); recv(r);
        chk("R7 invalid discarded", r, model[2]);

        // R10: preset, ticks, priority
        time_unix = 32'd0; time_load = 1'b1; waitc(1); time_load = 1'b0;
        exp_sec = 32'd2082844800;
        sec_check("R10 preset");
        for (int t = 0; t < 5; t++) begin
            tick_1hz = 1'b1; waitc(1); tick_1hz = 1'b0; waitc(1);
        end
        exp_sec = exp_sec + 5;
        sec_check("R10 ticks");
        time_unix = 32'd100; time_load = 1'b1; tick_1hz = 1'b1; waitc(1);
        time_load = 1'b0; tick_1hz = 1'b0;
        exp_sec = 32'd2082844800 + 100;
        sec_check("R10 load priority");
        // R4: all four seconds bytes exercised above; check byte order once more
        send(8'h8D); recv(r);
        chk("R4 top byte", r, exp_sec[31:24]);

        // R9: seconds and test writes consume data without effect
        send(8'h01); send(8'h55);
        send(8'h31); send(8'hFF);
        sec_check("R9 seconds unchanged");
        send(8'hC1 | 8'(6 << 2)); recv(r);
        chk("R9 sequencing", r, model[6]);

        // R8: write protect
        send(8'h35); send(8'h80);
        send(8'h41 | 8'(7 << 2)); send(8'h00);
        send(8'h3D); send(8'h00); send(8'h00);
        send(8'h31); send(8'h00);
        send(8'hC1 | 8'(7 << 2)); recv(r);
        chk("R8 direct blocked", r, model[7]);
        send(8'hBD); send(8'h00); recv(r);
        chk("R8 ext blocked", r, model[160]);
        send(8'h35); send(8'h7F);
        send(8'h41 | 8'(7 << 2)); send(8'hA5); model[7] = 8'hA5;
        send(8'hC1 | 8'(7 << 2)); recv(r);
        chk("R8 unprotected write", r, 8'hA5);

        // R2: reset clears protect and byte alignment; R11
        send(8'h35); send(8'h80);
        rst = 1'b1; waitc(3); rst = 1'b0; waitc(4);
        send(8'h41 | 8'(1 << 2)); send(8'h5A); model[1] = 8'h5A;
        send(8'hC1 | 8'(1 << 2)); recv(r);
        chk("R2 R11 after reset", r, 8'h5A);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule